// File: doc/BRIEF.md
# Strap-Addressed Serial Target Front End with Busy Lockout

This block is the bus-facing half of a two-wire serial target that runs on the system clock. It oversamples the raw SCL and SDA lines through synchronizers and derives START, STOP and clock-edge events from them. It assembles bytes MSB first and checks the first byte of each frame against a fixed type nibble plus four strap inputs. Every accepted byte is handed to a command engine, tagged with its place in the frame: address, instruction, or data.

The front end acknowledges the address and every byte it receives. When the command engine asks for a read, the target shifts out bytes the engine supplies and keeps going for as long as the master acknowledges them. While the engine reports an internal program cycle, the target ignores its own address. A host can therefore poll for completion by sending START plus address repeatedly until the target acknowledges again.

Top module: `strap_i2c_target`

## Requirements
- R1: After synchronous reset, `sda_pull` is 0 and `rx_valid`, `rd_take` and `bus_stop` are 0 until bus activity occurs.
- R2: A first byte whose upper nibble equals `TYPE_CODE` (default 4'b0101) and whose lower nibble equals `strap` is acknowledged. The target pulls SDA low through the ninth clock and pulses `rx_valid` with `rx_kind` = 0 (address).
- R3: A first byte that differs from the expected value in the type nibble or the strap nibble gets no acknowledge and no `rx_valid`. Later bytes of the same frame get no acknowledge either, until the next START or STOP.
- R4: While `busy` is 1 when the eighth address bit is sampled, a matching address gets no acknowledge and no `rx_valid`, and the target stays silent for the rest of the frame.
- R5: After an accepted address, each received byte is acknowledged and reported MSB first on `rx_byte`. The second byte of the frame carries `rx_kind` = 1 (instruction), and all later bytes carry `rx_kind` = 2 (data).
- R6: If `rd_en` is 1 at the end of the acknowledge that closes the instruction byte, the target transmits `rd_data` MSB first. It changes SDA only while SCL is low and releases SDA for the ninth clock. `rd_take` pulses once for each byte loaded.
- R7: A master acknowledge (SDA low in the ninth clock) makes the target load and send the next byte. A master non-acknowledge stops all driving until the next START or STOP.
- R8: An SDA change while SCL is high is taken only as START (falling) or STOP (rising), never as data. A repeated START restarts the frame in the address phase.
- R9: A STOP releases SDA, returns the target to idle and pulses `bus_stop` for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the bus |
| strap | input | 4 | Pin-strapped low nibble of the target address |
| busy | input | 1 | Program cycle in progress; address is not acknowledged |
| rd_en | input | 1 | Command engine requests a read data phase |
| rd_data | input | 8 | Byte to transmit in the read data phase |
| sda_pull | output | 1 | 1 drives SDA low (open-drain enable) |
| rx_valid | output | 1 | One-cycle pulse: a received byte is available |
| rx_byte | output | 8 | Received byte, valid with `rx_valid` |
| rx_kind | output | 2 | Position of the byte: 0 address, 1 instruction, 2 data |
| rd_take | output | 1 | One-cycle pulse when `rd_data` has been loaded for sending |
| bus_stop | output | 1 | One-cycle pulse on a detected STOP |

## Verification
The bench builds the target with `SYNC_STAGES` = 3 and `TYPE_CODE` left at 4'b0101, so the longer synchronizer delay is tested against a bus quarter-period of eight clocks. The vector table changes the strap value from frame to frame and corrupts each nibble of the address separately. It also raises `busy` against an otherwise matching address, which exercises both halves of the address gate and the ACK polling case. Directed frames then cover writes, a read that continues after a master acknowledge and stops after a non-acknowledge, a repeated START, and a STOP in the middle of a byte.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W) + 1;

    typedef enum logic [1:0] {
        POS_ADDR  = 2'd0,
        POS_INSTR = 2'd1,
        POS_DATA  = 2'd2
    } byte_pos_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_ARM,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_TX_NEXT,
        ST_WAIT
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [3:0] type_code,
                                      input logic [3:0] strap_val);
        return (b[7:4] == type_code) && (b[3:0] == strap_val);
    endfunction

    function automatic byte_pos_e next_pos(input byte_pos_e p);
        return (p == POS_ADDR) ? POS_INSTR : POS_DATA;
    endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    // Bus lines idle high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= d_in;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_out = pipe[STAGES-1];
endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events
    import i2ct_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // SCL must be high on both samples for an SDA edge to count as a condition.
    always_comb begin
        evt.start    = scl_q & scl_s & sda_q & ~sda_s;
        evt.stop     = scl_q & scl_s & ~sda_q & sda_s;
        evt.scl_rise = ~scl_q & scl_s;
        evt.scl_fall = scl_q & ~scl_s;
        evt.scl      = scl_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
    import i2ct_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] TYPE_CODE   = 4'b0101
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic [3:0]  strap,
    input  logic        busy,
    input  logic        rd_en,
    input  logic [7:0]  rd_data,
    output logic        sda_pull,
    output logic        rx_valid,
    output logic [7:0]  rx_byte,
    output logic [1:0]  rx_kind,
    output logic        rd_take,
    output logic        bus_stop
);
    localparam int LAST_BIT = BYTE_W - 1;

    logic [1:0]            line_s;
    bus_evt_t              evt;
    tgt_state_e            state;
    byte_pos_e             pos;
    logic [BIT_CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0]     shreg;
    logic [BYTE_W-1:0]     rx_next;

    i2ct_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({scl_in, sda_in}),
        .q_out (line_s)
    );

    i2ct_bus_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_s (line_s[1]),
        .sda_s (line_s[0]),
        .evt   (evt)
    );

    assign rx_next = {shreg[BYTE_W-2:0], evt.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pos      <= POS_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            sda_pull <= 1'b0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
            rx_kind  <= POS_ADDR;
            rd_take  <= 1'b0;
            bus_stop <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rd_take  <= 1'b0;
            bus_stop <= 1'b0;
            if (evt.stop) begin
                state    <= ST_IDLE;
                pos      <= POS_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
                bus_stop <= 1'b1;
            end else if (evt.start) begin
                state    <= ST_RX;
                pos      <= POS_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: if (evt.scl_rise) begin
                        shreg  <= rx_next;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == BIT_CNT_W'(LAST_BIT)) begin
                            if (pos == POS_ADDR &&
                                (!addr_hit(rx_next, TYPE_CODE, strap) || busy)) begin
                                state <= ST_WAIT;
                            end else begin
                                rx_valid <= 1'b1;
                                rx_byte  <= rx_next;
                                rx_kind  <= pos;
                                state    <= ST_ACK_ARM;
                            end
                        end
                    end
                    ST_ACK_ARM: if (evt.scl_fall) begin
                        sda_pull <= 1'b1;
                        state    <= ST_ACK;
                    end
                    ST_ACK: if (evt.scl_fall) begin
                        bitcnt <= '0;
                        pos    <= next_pos(pos);
                        if (next_pos(pos) == POS_DATA && rd_en) begin
                            shreg    <= rd_data;
                            sda_pull <= ~rd_data[LAST_BIT];
                            rd_take  <= 1'b1;
                            state    <= ST_TX;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (bitcnt == BIT_CNT_W'(BYTE_W)) begin
                                sda_pull <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                shreg    <= shreg << 1;
                                sda_pull <= ~shreg[LAST_BIT-1];
                            end
                        end
                    end
                    ST_MACK: if (evt.scl_rise) begin
                        state <= evt.sda ? ST_WAIT : ST_TX_NEXT;
                    end
                    ST_TX_NEXT: if (evt.scl_fall) begin
                        bitcnt   <= '0;
                        shreg    <= rd_data;
                        sda_pull <= ~rd_data[LAST_BIT];
                        rd_take  <= 1'b1;
                        state    <= ST_TX;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1 / R3 / R7: no drive while idle or waiting out a rejected or ended frame
    p_quiet_states_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_WAIT) |-> !sda_pull);

    // R6: SDA drive moves only while the synchronized SCL is low
    p_drive_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pull) && !$past(evt.start) && !$past(evt.stop)) |-> !evt.scl);

    // R4: busy at the last address bit suppresses the report
    p_busy_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && state == ST_RX && pos == POS_ADDR && evt.scl_rise && !evt.start &&
         !evt.stop && bitcnt == BIT_CNT_W'(LAST_BIT)) |=> !rx_valid);

    // R8: START rewinds to the address phase with SDA released
    p_start_rewind_r8: assert property (@(posedge clk) disable iff (rst)
        (evt.start && !evt.stop) |=> (pos == POS_ADDR && bitcnt == '0 && !sda_pull));

    // R9: STOP releases SDA and pulses bus_stop
    p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (bus_stop && !sda_pull));

    // R6: a read byte is only loaded in the data phase
    p_take_data_r6: assert property (@(posedge clk) disable iff (rst)
        rd_take |-> (pos == POS_DATA && state == ST_TX));
endmodule

// File: tb/tb_strap_i2c_target.sv
module tb_strap_i2c_target;
    logic       clk = 1'b0;
    logic       rst;
    logic       scl_m, sda_m;
    logic [3:0] strap;
    logic       busy, rd_en;
    logic [7:0] rd_data;
    logic       sda_pull, rx_valid, rd_take, bus_stop;
    logic [7:0] rx_byte;
    logic [1:0] rx_kind;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] log_b [64];
    logic [1:0] log_k [64];
    int n_rx   = 0;
    int n_take = 0;
    int n_stop = 0;

    always #2 clk = ~clk;   // 250 MHz

    assign sda_line = sda_m & ~sda_pull;

    strap_i2c_target #(.SYNC_STAGES(3), .TYPE_CODE(4'b0101)) dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .strap(strap), .busy(busy), .rd_en(rd_en), .rd_data(rd_data),
        .sda_pull(sda_pull), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_kind(rx_kind), .rd_take(rd_take), .bus_stop(bus_stop)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (rx_valid && n_rx < 64) begin
                log_b[n_rx] <= rx_byte;
                log_k[n_rx] <= rx_kind;
            end
            if (rx_valid) n_rx <= n_rx + 1;
            if (bus_stop) n_stop <= n_stop + 1;
            if (rd_take) begin
                n_take  <= n_take + 1;
                rd_data <= rd_data ^ 8'h99;
            end
        end
    end

    typedef struct packed {
        logic [3:0] strap;
        logic [7:0] addr;
        logic       busy;
        logic       ack;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{4'hA, 8'h5A, 1'b0, 1'b1},
        '{4'h0, 8'h50, 1'b0, 1'b1},
        '{4'hF, 8'h5F, 1'b0, 1'b1},
        '{4'hA, 8'h5B, 1'b0, 1'b0},
        '{4'hA, 8'hDA, 1'b0, 1'b0},
        '{4'h3, 8'h53, 1'b1, 1'b0},
        '{4'h3, 8'h53, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop_cond();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    waitq();
        scl_m = 1'b1; waitq(); waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        b = sda_line; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic bit_v;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        read_bit(bit_v);
        ack = ~bit_v;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic bit_v;
        for (int i = 7; i >= 0; i--) begin
            read_bit(bit_v);
            v[i] = bit_v;
        end
        send_bit(~mack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b1, b2, b3;
        int base;
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; strap = 4'hA;
        busy = 1'b0; rd_en = 1'b0; rd_data = 8'hA5;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk(sda_pull == 1'b0, "R1 sda_pull", 32'(sda_pull), 0);
        chk(n_rx == 0, "R1 rx_valid", n_rx, 0);
        chk(n_take == 0 && n_stop == 0, "R1 rd_take/bus_stop", n_take + n_stop, 0);

        // R2 / R3 / R4: address table
        for (int v = 0; v < NVEC; v++) begin
            strap = VECS[v].strap;
            busy  = VECS[v].busy;
            base  = n_rx;
            bus_start();
            send_byte(VECS[v].addr, ack);
            chk(ack == VECS[v].ack, VECS[v].busy ? "R4 busy ack" : "R2/R3 addr ack",
                32'(ack), 32'(VECS[v].ack));
            chk(n_rx - base == int'(VECS[v].ack), "R2/R3/R4 rx_valid count",
                n_rx - base, int'(VECS[v].ack));
            if (VECS[v].ack)
                chk(log_k[base] == 2'd0 && log_b[base] == VECS[v].addr, "R2 addr kind/byte",
                    {22'd0, log_k[base], log_b[base]}, {22'd0, 2'd0, VECS[v].addr});
            else begin
                send_byte(8'h90, ack);
                chk(ack == 1'b0, "R3 later byte ignored", 32'(ack), 0);
            end
            bus_stop_cond();
            busy = 1'b0;
        end

        // R5: write frame
        strap = 4'hA;
        base  = n_rx;
        bus_start();
        send_byte(8'h5A, ack); b1[0] = ack;
        send_byte(8'hA4, ack); b1[1] = ack;
        send_byte(8'h2B, ack); b1[2] = ack;
        send_byte(8'h15, ack); b1[3] = ack;
        bus_stop_cond();
        chk(b1[3:0] == 4'hF, "R5 all bytes acked", 32'(b1[3:0]), 32'hF);
        chk(n_rx - base == 4, "R5 byte count", n_rx - base, 4);
        chk({log_k[base+1], log_b[base+1]} == {2'd1, 8'hA4}, "R5 instruction",
            {log_k[base+1], log_b[base+1]}, {2'd1, 8'hA4});
        chk({log_k[base+2], log_b[base+2], log_k[base+3], log_b[base+3]} ==
            {2'd2, 8'h2B, 2'd2, 8'h15}, "R5 data bytes",
            {log_k[base+2], log_b[base+2], log_k[base+3], log_b[base+3]},
            {2'd2, 8'h2B, 2'd2, 8'h15});

        // R6 / R7: read frame
        rd_en = 1'b1;
        bus_start();
        send_byte(8'h5A, ack);
        send_byte(8'hB4, ack);
        recv_byte(b1, 1'b1);
        recv_byte(b2, 1'b0);
        recv_byte(b3, 1'b1);
        bus_stop_cond();
        rd_en = 1'b0;
        chk(b1 == 8'hA5, "R6 first read byte", b1, 8'hA5);
        chk(b2 == 8'h3C, "R7 byte after master ack", b2, 8'h3C);
        chk(b3 == 8'hFF, "R7 silent after nack", b3, 8'hFF);
        chk(n_take == 2, "R6 rd_take count", n_take, 2);

        // R8: repeated START restarts address phase
        base = n_rx;
        bus_start();
        send_byte(8'h5A, ack);
        send_byte(8'hA0, ack);
        bus_start();
        send_byte(8'h5A, ack);
        chk(ack == 1'b1, "R8 ack after repeated start", 32'(ack), 1);
        chk(n_rx - base == 3 && log_k[base+2] == 2'd0, "R8 restart kind",
            {n_rx - base, 30'(log_k[base+2])}, {32'd3, 30'd0});
        bus_stop_cond();

        // R8 / R9: STOP in the middle of a byte
        base = n_stop;
        bus_start();
        send_byte(8'h5A, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_stop_cond();
        chk(n_stop - base == 2 - 1, "R9 bus_stop pulse", n_stop - base, 1);
        chk(sda_line == 1'b1, "R9 line released", 32'(sda_line), 1);
        bus_start();
        send_byte(8'h5A, ack);
        chk(ack == 1'b1, "R8 fresh frame after mid-byte stop", 32'(ack), 1);
        bus_stop_cond();

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule